// File: doc/BRIEF.md
# Sub-word Min/Max Unit

This block takes two operands, A and B, and picks a byte, a halfword or the whole 32-bit word from each one. It sign-extends or zero-extends each picked field and then returns either the smaller or the larger of the two. B can come from a register or from a 16-bit immediate. The block handles a pair in which one operand is signed and the other is unsigned by applying a fixed rule set. It can then clamp the result to the range of the destination's signedness.

After that, a secondary step combines the result with a third operand C. The result can be added to C, compared with C again, or written into one halfword or one byte of a copy of C while the rest of C is kept. The unit samples its inputs on a valid strobe and presents the registered result with a matching valid one clock later. An instruction pipeline uses it as the execute stage for packed-integer min/max work.

Top module: `smm_unit`

## Requirements
- R1: Each operand select is 4 bits. Bit 3 set means the field is signed. Bits 2:0 pick the field: 0 to 3 pick byte 0 to 3 (byte k is bits 8k+7:8k), 4 and 5 pick halfword 0 and 1, and 6 and 7 pick the full word. The field is sign-extended to 32 bits when signed and zero-extended otherwise.
- R2: When `b_use_reg` is 0, the B operand is the 16-bit immediate. The immediate is sign-extended when bit 3 of `b_sel` is set and zero-extended when it is clear. Bits 2:0 of `b_sel` have no effect in this case.
- R3: When A and B have the same signedness, the compare uses that shared signedness. `want_max`=1 returns the larger operand and 0 returns the smaller. The result counts as signed exactly when both operands are signed.
- R4: When A and B have different signedness, `want_max`=1 returns the unsigned maximum and the result counts as unsigned. `want_max`=0 returns the signed minimum and the result counts as signed.
- R5: In the mixed-signedness case, if the operand on the unsigned side has bit 31 set, that operand is the result, for both min and max.
- R6: With `sat_en`=1, a signed destination (`dst_signed`=1) and an unsigned result, the result is capped at 0x7FFFFFFF. With `sat_en`=1, an unsigned destination and a signed result, a negative result becomes 0. In every other case saturation leaves the value unchanged.
- R7: `sec_op`=1 adds C to the result, modulo 2^32.
- R8: `sec_op`=2 returns the larger and `sec_op`=3 the smaller of the result and C. The compare is signed when `dst_signed`=1 and unsigned otherwise.
- R9: The merge codes write the low bits of the result into a copy of C and keep every other bit of C. `sec_op`=4 puts result bits 15:0 into bits 31:16. `sec_op`=5 puts them into bits 15:0. `sec_op`=6 puts result bits 7:0 into bits 7:0. `sec_op`=7 puts them into bits 23:16.
- R10: `sec_op`=0 passes the saturated min/max result through unchanged.
- R11: An input accepted with `in_valid`=1 appears on `result` with `out_valid`=1 on the next clock. Without `in_valid`, `out_valid` is 0 on the next clock and `result` holds its previous value.
- R12: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe: sample the operands and controls |
| a_reg | input | 32 | A source word |
| b_reg | input | 32 | B source word, used when `b_use_reg`=1 |
| c_reg | input | 32 | C operand for the secondary step |
| imm | input | 16 | Immediate for B, used when `b_use_reg`=0 |
| a_sel | input | 4 | A field select and signedness |
| b_sel | input | 4 | B field select and signedness |
| b_use_reg | input | 1 | 1: B from `b_reg`, 0: B from `imm` |
| want_max | input | 1 | 1: maximum, 0: minimum |
| sat_en | input | 1 | Enable saturation to the destination range |
| dst_signed | input | 1 | Destination is signed |
| sec_op | input | 3 | Secondary operation code |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 32 | Registered result |

## Verification
The compare is exercised with operand pairs of matching signedness on byte, halfword and word fields. These pairs separate a signed compare from an unsigned one, because a negative value lands on the opposite side in each. Mixed-signedness pairs are tried twice: once with the unsigned-side operand below 2^31, to confirm the base rule, and once above it, to confirm the forced result. Saturation is tried with results on both sides of the sign boundary. Each secondary code is applied against C values with their top bit set, which shows whether the C compare follows the destination signedness and whether a merge disturbs the bits it should keep. A long run of pseudo-random operands with idle gaps mixes all of these and shows that the result holds between strobes.

// File: rtl/smm_pkg.sv
package smm_pkg;

  typedef enum logic [2:0] {
    SEC_NONE = 3'd0,
    SEC_ACC  = 3'd1,
    SEC_MAX  = 3'd2,
    SEC_MIN  = 3'd3,
    SEC_HI16 = 3'd4,
    SEC_LO16 = 3'd5,
    SEC_B0   = 3'd6,
    SEC_B2   = 3'd7
  } sec_op_e;

  localparam int SEL_W          = 4;
  localparam int SEL_SIGNED_BIT = 3;

endpackage

// File: rtl/smm_operand_ext.sv
module smm_operand_ext #(
  parameter int DW    = 32,
  parameter int IMM_W = 16
) (
  input  logic [DW-1:0]          reg_val,
  input  logic [IMM_W-1:0]       imm_val,
  input  logic                   use_reg,
  input  logic [smm_pkg::SEL_W-1:0] sel,
  output logic [DW-1:0]          ext_val,
  output logic                   is_signed
);
  localparam int QW = DW / 4;
  localparam int HW = DW / 2;

  logic [DW-1:0] byte_ext [4];
  logic [DW-1:0] half_ext [2];
  logic [DW-1:0] reg_ext;
  logic [DW-1:0] imm_ext;

  assign is_signed = sel[smm_pkg::SEL_SIGNED_BIT];

  for (genvar k = 0; k < 4; k++) begin : g_byte
    assign byte_ext[k] = is_signed
      ? {{(DW-QW){reg_val[k*QW+QW-1]}}, reg_val[k*QW +: QW]}
      : {{(DW-QW){1'b0}}, reg_val[k*QW +: QW]};
  end

  for (genvar k = 0; k < 2; k++) begin : g_half
    assign half_ext[k] = is_signed
      ? {{(DW-HW){reg_val[k*HW+HW-1]}}, reg_val[k*HW +: HW]}
      : {{(DW-HW){1'b0}}, reg_val[k*HW +: HW]};
  end

  always_comb begin
    case (sel[2:0])
      3'd0: reg_ext = byte_ext[0];
      3'd1: reg_ext = byte_ext[1];
      3'd2: reg_ext = byte_ext[2];
      3'd3: reg_ext = byte_ext[3];
      3'd4: reg_ext = half_ext[0];
      3'd5: reg_ext = half_ext[1];
      default: reg_ext = reg_val;
    endcase
  end

  assign imm_ext = is_signed ? {{(DW-IMM_W){imm_val[IMM_W-1]}}, imm_val}
                             : {{(DW-IMM_W){1'b0}}, imm_val};

  assign ext_val = use_reg ? reg_ext : imm_ext;

endmodule

// File: rtl/smm_minmax_core.sv
module smm_minmax_core #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic          want_max,
  output logic [DW-1:0] mm_val,
  output logic          mm_signed,
  output logic          mixed,
  output logic          override_hit
);
  function automatic logic [DW-1:0] pick_u(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic larger);
    logic x_gt;
    x_gt = x > y;
    return (x_gt == larger) ? x : y;
  endfunction

  function automatic logic [DW-1:0] pick_s(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic larger);
    logic x_gt;
    x_gt = $signed(x) > $signed(y);
    return (x_gt == larger) ? x : y;
  endfunction

  logic [DW-1:0] same_val;
  logic [DW-1:0] mix_base;
  logic          a_forces;
  logic          b_forces;

  assign mixed    = a_signed ^ b_signed;
  assign same_val = a_signed ? pick_s(a_val, b_val, want_max)
                             : pick_u(a_val, b_val, want_max);
  assign mix_base = want_max ? pick_u(a_val, b_val, 1'b1)
                             : pick_s(a_val, b_val, 1'b0);

  // the unsigned-side operand wins when its top bit is set
  assign b_forces     = a_signed & b_val[DW-1];
  assign a_forces     = b_signed & a_val[DW-1];
  assign override_hit = mixed & (a_forces | b_forces);

  always_comb begin
    if (!mixed) begin
      mm_val    = same_val;
      mm_signed = a_signed;
    end else begin
      mm_signed = ~want_max;
      if (b_forces)      mm_val = b_val;
      else if (a_forces) mm_val = a_val;
      else               mm_val = mix_base;
    end
  end

endmodule

// File: rtl/smm_post_op.sv
module smm_post_op
  import smm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] mm_val,
  input  logic          mm_signed,
  input  logic          sat_en,
  input  logic          dst_signed,
  input  logic [DW-1:0] c_val,
  input  sec_op_e       op,
  output logic [DW-1:0] sat_val,
  output logic [DW-1:0] post_val
);
  localparam int QW = DW / 4;
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};

  function automatic logic [DW-1:0] combine(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                            input logic sgn, input logic larger);
    logic x_gt;
    x_gt = sgn ? ($signed(x) > $signed(y)) : (x > y);
    return (x_gt == larger) ? x : y;
  endfunction

  logic cap_hi;
  logic floor_lo;

  assign cap_hi   = sat_en &  dst_signed & ~mm_signed & mm_val[DW-1];
  assign floor_lo = sat_en & ~dst_signed &  mm_signed & mm_val[DW-1];

  always_comb begin
    if (cap_hi)        sat_val = POS_MAX;
    else if (floor_lo) sat_val = '0;
    else               sat_val = mm_val;
  end

  always_comb begin
    post_val = c_val;
    case (op)
      SEC_ACC:  post_val = sat_val + c_val;
      SEC_MAX:  post_val = combine(sat_val, c_val, dst_signed, 1'b1);
      SEC_MIN:  post_val = combine(sat_val, c_val, dst_signed, 1'b0);
      SEC_HI16: post_val[HW +: HW]   = sat_val[HW-1:0];
      SEC_LO16: post_val[0 +: HW]    = sat_val[HW-1:0];
      SEC_B0:   post_val[0 +: QW]    = sat_val[QW-1:0];
      SEC_B2:   post_val[2*QW +: QW] = sat_val[QW-1:0];
      default:  post_val = sat_val;
    endcase
  end

endmodule

// File: rtl/smm_unit.sv
module smm_unit
  import smm_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a_reg,
  input  logic [DW-1:0] b_reg,
  input  logic [DW-1:0] c_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [3:0]    a_sel,
  input  logic [3:0]    b_sel,
  input  logic          b_use_reg,
  input  logic          want_max,
  input  logic          sat_en,
  input  logic          dst_signed,
  input  logic [2:0]    sec_op,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  logic [DW-1:0] a_ext;
  logic [DW-1:0] b_ext;
  logic          a_signed;
  logic          b_signed;
  logic [DW-1:0] mm_val;
  logic          mm_signed;
  logic          mixed;
  logic          override_hit;
  logic [DW-1:0] sat_val;
  logic [DW-1:0] post_val;

  smm_operand_ext #(.DW(DW), .IMM_W(IMM_W)) u_ext_a (
    .reg_val(a_reg), .imm_val('0), .use_reg(1'b1), .sel(a_sel),
    .ext_val(a_ext), .is_signed(a_signed)
  );

  smm_operand_ext #(.DW(DW), .IMM_W(IMM_W)) u_ext_b (
    .reg_val(b_reg), .imm_val(imm), .use_reg(b_use_reg), .sel(b_sel),
    .ext_val(b_ext), .is_signed(b_signed)
  );

  smm_minmax_core #(.DW(DW)) u_core (
    .a_val(a_ext), .b_val(b_ext), .a_signed(a_signed), .b_signed(b_signed),
    .want_max(want_max), .mm_val(mm_val), .mm_signed(mm_signed),
    .mixed(mixed), .override_hit(override_hit)
  );

  smm_post_op #(.DW(DW)) u_post (
    .mm_val(mm_val), .mm_signed(mm_signed), .sat_en(sat_en),
    .dst_signed(dst_signed), .c_val(c_reg), .op(sec_op_e'(sec_op)),
    .sat_val(sat_val), .post_val(post_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= post_val;
    end
  end

endmodule

// File: rtl/smm_unit_chk.sv
module smm_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic [DW-1:0] c_reg,
  input logic [2:0]    sec_op,
  input logic          want_max,
  input logic          sat_en,
  input logic          dst_signed,
  input logic [DW-1:0] a_ext,
  input logic [DW-1:0] b_ext,
  input logic [DW-1:0] mm_val,
  input logic          mm_signed,
  input logic          mixed,
  input logic          override_hit,
  input logic [DW-1:0] sat_val
);
  localparam int QW = DW / 4;

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result))); // R11

  AST_PICKS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_val == a_ext) || (mm_val == b_ext)); // R3

  AST_MIXED_MAX_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mixed && want_max && !override_hit) |-> (mm_val >= a_ext && mm_val >= b_ext)); // R4

  AST_MIXED_MIN_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mixed && !want_max && !override_hit)
      |-> ($signed(mm_val) <= $signed(a_ext) && $signed(mm_val) <= $signed(b_ext))); // R4

  AST_SAT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && dst_signed && !mm_signed) |-> !sat_val[DW-1]); // R6

  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && !dst_signed && mm_signed) |-> !sat_val[DW-1]); // R6

  AST_MRG_B0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sec_op == 3'd6) |=> (result[DW-1:QW] == $past(c_reg[DW-1:QW]))); // R9

  AST_NONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sec_op == 3'd0) |=> (result == $past(sat_val))); // R10

endmodule

bind smm_unit smm_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .c_reg(c_reg), .sec_op(sec_op), .want_max(want_max),
  .sat_en(sat_en), .dst_signed(dst_signed), .a_ext(a_ext), .b_ext(b_ext),
  .mm_val(mm_val), .mm_signed(mm_signed), .mixed(mixed),
  .override_hit(override_hit), .sat_val(sat_val)
);

// File: tb/smm_unit_tb.sv
module smm_unit_tb_top;

  localparam longint M32   = 64'hFFFF_FFFF;
  localparam longint TWO31 = 64'h8000_0000;
  localparam longint TWO32 = 64'h1_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a_reg = '0, b_reg = '0, c_reg = '0;
  logic [15:0] imm = '0;
  logic [3:0]  a_sel = '0, b_sel = '0;
  logic        b_use_reg = 1'b1, want_max = 1'b0, sat_en = 1'b0, dst_signed = 1'b0;
  logic [2:0]  sec_op = '0;
  logic        out_valid;
  logic [31:0] result;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 0;
  string cur_tag = "R11";

  logic        exp_valid;
  logic [31:0] exp_res;
  string       exp_tag;

  always #5 clk = ~clk;

  smm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_reg(a_reg), .b_reg(b_reg),
    .c_reg(c_reg), .imm(imm), .a_sel(a_sel), .b_sel(b_sel), .b_use_reg(b_use_reg),
    .want_max(want_max), .sat_en(sat_en), .dst_signed(dst_signed), .sec_op(sec_op),
    .out_valid(out_valid), .result(result)
  );

  // value of a field as a mathematical integer (R1)
  function automatic longint field_value(input logic [31:0] r, input logic [3:0] s);
    int lo, w;
    longint f;
    if (s[2:0] < 3'd4) begin lo = 8 * int'(s[2:0]); w = 8; end
    else if (s[2:0] < 3'd6) begin lo = 16 * (int'(s[2:0]) - 4); w = 16; end
    else begin lo = 0; w = 32; end
    f = (longint'({32'd0, r}) >> lo) & ((longint'(1) << w) - 1);
    if (s[3] && f >= (longint'(1) << (w - 1))) f = f - (longint'(1) << w);
    return f;
  endfunction

  function automatic longint as_signed(input longint u);
    return (u >= TWO31) ? u - TWO32 : u;
  endfunction

  function automatic logic [31:0] ref_model(
    input logic [31:0] ra, input logic [31:0] rb, input logic [31:0] rc,
    input logic [15:0] im, input logic [3:0] sa_sel, input logic [3:0] sb_sel,
    input logic use_b, input logic mx, input logic sat, input logic ds, input logic [2:0] op);
    longint a, b, ua, ub, m, mu, cu, sc, sm;
    bit sa, sb, rs;
    logic [31:0] out;
    sa = sa_sel[3];
    sb = sb_sel[3];
    a  = field_value(ra, sa_sel);
    if (use_b) b = field_value(rb, sb_sel);
    else b = (sb && im[15]) ? longint'({48'd0, im}) - 65536 : longint'({48'd0, im});
    ua = a & M32;
    ub = b & M32;
    if (sa == sb) begin
      rs = sa;
      if (sa) m = (mx == (as_signed(ua) > as_signed(ub))) ? a : b;
      else    m = (mx == (ua > ub)) ? a : b;
    end else begin
      rs = !mx;
      if (mx) m = (ua > ub) ? a : b;
      else    m = (as_signed(ua) < as_signed(ub)) ? a : b;
      if (sa && ub >= TWO31) m = b;
      else if (sb && ua >= TWO31) m = a;
    end
    mu = m & M32;
    if (sat && ds && !rs && mu > 64'h7FFF_FFFF) mu = 64'h7FFF_FFFF;
    if (sat && !ds && rs && mu >= TWO31) mu = 0;
    cu = longint'({32'd0, rc});
    sc = ds ? as_signed(cu) : cu;
    sm = ds ? as_signed(mu) : mu;
    case (op)
      3'd1: mu = (mu + cu) & M32;
      3'd2: mu = (sm >= sc) ? mu : cu;
      3'd3: mu = (sm <= sc) ? mu : cu;
      3'd4: mu = (cu & 64'h0000_FFFF) | ((mu & 64'hFFFF) << 16);
      3'd5: mu = (cu & 64'hFFFF_0000) | (mu & 64'hFFFF);
      3'd6: mu = (cu & 64'hFFFF_FF00) | (mu & 64'hFF);
      3'd7: mu = (cu & 64'hFF00_FFFF) | ((mu & 64'hFF) << 16);
      default: ;
    endcase
    out = mu[31:0];
    return out;
  endfunction

  // reference pipeline: one register stage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res   <= '0;
      exp_tag   <= "R12";
    end else begin
      exp_valid <= in_valid;
      exp_tag   <= in_valid ? cur_tag : "R11";
      if (in_valid)
        exp_res <= ref_model(a_reg, b_reg, c_reg, imm, a_sel, b_sel, b_use_reg,
                             want_max, sat_en, dst_signed, sec_op);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      n_tests++;
      if (out_valid !== exp_valid || result !== exp_res) begin
        n_fail++;
        $display("FAIL %s: valid=%0b result=%08h expected valid=%0b result=%08h",
                 exp_tag, out_valid, result, exp_valid, exp_res);
      end
    end
  end

  task automatic drive(input string tag, input logic [31:0] ra, input logic [31:0] rb,
                       input logic [31:0] rc, input logic [15:0] im,
                       input logic [3:0] sa, input logic [3:0] sb, input logic ub,
                       input logic mx, input logic st, input logic ds, input logic [2:0] op);
    @(negedge clk);
    cur_tag = tag;
    a_reg = ra; b_reg = rb; c_reg = rc; imm = im;
    a_sel = sa; b_sel = sb; b_use_reg = ub;
    want_max = mx; sat_en = st; dst_signed = ds; sec_op = op;
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_reg = a_reg ^ 32'h5A5A_A5A5;
      c_reg = ~c_reg;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);   // reset checks, R12
    rst_n = 1'b1;
    idle(2);

    // R1: field selects
    drive("R1", 32'h7F00_8000, 32'h0000_00FF, 0, 0, 4'h1, 4'h3, 1, 1, 0, 0, 3'd0);
    drive("R1", 32'h8001_7FFF, 32'hFFFF_0002, 0, 0, 4'hC, 4'hD, 1, 0, 0, 0, 3'd0);
    drive("R1", 32'h0080_0000, 32'h1234_0000, 0, 0, 4'hA, 4'h5, 1, 1, 0, 0, 3'd0);
    drive("R1", 32'hCAFE_BABE, 32'h1234_5678, 0, 0, 4'h6, 4'h7, 1, 0, 0, 0, 3'd0);
    // R2: immediate extension, field bits ignored
    drive("R2", 32'h0000_0005, 32'hFFFF_FFFF, 0, 16'hFFF0, 4'hE, 4'hE, 0, 0, 0, 0, 3'd0);
    drive("R2", 32'h0000_0005, 32'h0000_0000, 0, 16'hFFF0, 4'h6, 4'h3, 0, 1, 0, 0, 3'd0);
    drive("R2", 32'h0000_0005, 32'h0000_0000, 0, 16'h8000, 4'hE, 4'h9, 0, 1, 0, 0, 3'd0);
    // R3: same signedness
    drive("R3", 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 4'hE, 4'hE, 1, 1, 0, 0, 3'd0);
    drive("R3", 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd0);
    drive("R3", 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 4'h6, 4'h6, 1, 0, 0, 0, 3'd0);
    // R4: mixed signedness, no forcing
    drive("R4", 32'h0000_00FB, 32'h0000_0007, 0, 0, 4'h8, 4'h6, 1, 0, 0, 0, 3'd0);
    drive("R4", 32'h0000_00FB, 32'h0000_0007, 0, 0, 4'h8, 4'h6, 1, 1, 0, 0, 3'd0);
    drive("R4", 32'h0000_0009, 32'hFFFF_FFFD, 0, 0, 4'h6, 4'hE, 1, 0, 0, 0, 3'd0);
    // R5: unsigned side has top bit set
    drive("R5", 32'h0000_0001, 32'h8000_0000, 0, 0, 4'hE, 4'h6, 1, 0, 0, 0, 3'd0);
    drive("R5", 32'h9000_0000, 32'h7000_0000, 0, 0, 4'h6, 4'hE, 1, 1, 0, 0, 3'd0);
    // R6: saturation
    drive("R6", 32'h0000_0001, 32'hF000_0000, 0, 0, 4'hE, 4'h6, 1, 1, 1, 1, 3'd0);
    drive("R6", 32'hFFFF_FFFB, 32'h0000_0003, 0, 0, 4'hE, 4'hE, 1, 0, 1, 0, 3'd0);
    drive("R6", 32'hFFFF_FFFB, 32'h0000_0003, 0, 0, 4'hE, 4'hE, 1, 0, 1, 1, 3'd0);
    drive("R6", 32'hF000_0000, 32'h0000_0003, 0, 0, 4'h6, 4'h6, 1, 1, 0, 1, 3'd0);
    // R7: accumulate with wrap
    drive("R7", 32'h0000_0002, 32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd1);
    // R8: compare with C by destination signedness
    drive("R8", 32'h0000_0003, 32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 1, 3'd2);
    drive("R8", 32'h0000_0003, 32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd2);
    drive("R8", 32'h0000_0003, 32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 1, 3'd3);
    drive("R8", 32'h0000_0003, 32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd3);
    // R9: merges into C
    drive("R9", 32'h1234_ABCD, 32'h0, 32'hDEAD_BEEF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd4);
    drive("R9", 32'h1234_ABCD, 32'h0, 32'hDEAD_BEEF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd5);
    drive("R9", 32'h1234_ABCD, 32'h0, 32'hDEAD_BEEF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd6);
    drive("R9", 32'h1234_ABCD, 32'h0, 32'hDEAD_BEEF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd7);
    // R10: pass-through code
    drive("R10", 32'h5555_0000, 32'h0, 32'hFFFF_FFFF, 0, 4'h6, 4'h6, 1, 1, 0, 0, 3'd0);
    // R11: gap keeps the result
    idle(3);
    drive("R11", 32'h0000_0042, 32'h0, 32'h0, 0, 4'h0, 4'h0, 1, 1, 0, 0, 3'd0);
    idle(2);

    for (int i = 0; i < 400; i++) begin
      drive("R1", $urandom, $urandom, $urandom, 16'($urandom), 4'($urandom), 4'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule